// File: doc/BRIEF.md
# Two-Wire Bus Slave Register Interface

This block is a slave on a two-wire serial bus (clock line and open-drain data line). It holds a 256-entry file of 8-bit registers that a bus master reads and writes. Both bus lines are brought into the system clock domain through a two-stage synchroniser and then edge-detected, so all protocol decoding runs synchronously. The data line is driven only low, through an output-enable; the pad pulls it low when the enable is high.

The 7-bit device address has a fixed upper part and a low part taken from strap inputs, sampled once when reset is released. After a matching address byte with the write flag, the first data byte sets an internal sub-address pointer and later bytes are stored at the pointed register. A read returns bytes from the pointer onward. The pointer survives a repeated START, which allows a write-pointer-then-read message. A STOP after a matched address returns the pointer to zero. A parameter mask marks registers as read-only.

Top module: `twi_reg_slave`

## Requirements
- R1: The device address is {2'b00, strap[4:0]}. The strap value is captured in the first clock after reset release, and later changes of the strap pins have no effect until the next reset.
- R2: Bytes travel most significant bit first. Bit 0 of the address byte is the direction flag: 1 means the slave transmits and 0 means the slave receives.
- R3: The slave acknowledges a matching address byte, and every byte it receives after one, by driving SDA low throughout the ninth clock.
- R4: In a write, the first data byte loads the 8-bit pointer. Each later byte is stored at the pointed register. The pointer then advances by one after every byte written or read, wrapping from 0xFF to 0x00.
- R5: A START or repeated START leaves the pointer unchanged, so a read after a repeated START continues from the pointer the write left.
- R6: A STOP that follows a matched address sets the pointer to 0x00, so a read after it returns register 0x00 first.
- R7: After an address byte that does not match, the slave neither acknowledges nor drives SDA, and it changes no register until a later START carries a matching address.
- R8: In a read, the slave sends a new byte after each master ACK (SDA low in the ninth clock). After a master NACK it releases SDA and sends nothing more.
- R9: A register whose bit is set in the read-only mask ignores writes and reads as 0x00, but the pointer still advances over it. By default, registers 0xF0 to 0xFF are read-only.
- R10: After reset, SDA is released, every register holds 0x00 and the pointer is 0x00.
- R11: The SDA output enable changes only in the cycle after a detected SCL falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 5 | Low address bits, sampled after reset release |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
Two events can fall on the same system-clock edge. The first is a write landing on a read-only register while the pointer advances; the second is that same advance wrapping from 0xFF to 0x00. The bench provokes both by writing two bytes starting at pointer 0xFF. It then reads back from 0xFF and expects 0x00 followed by the second byte stored at register 0x00. The result shows that the write was suppressed while the pointer still stepped and wrapped in one move.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK
   } twi_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [STAGES-1:0] scl_chain, sda_chain;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_p     <= 1'b1;
         sda_p     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[STAGES-2:0], scl_in};
         sda_chain <= {sda_chain[STAGES-2:0], sda_in};
         scl_p     <= scl_chain[STAGES-1];
         sda_p     <= sda_chain[STAGES-1];
      end
   end

   assign scl_s    = scl_chain[STAGES-1];
   assign sda_s    = sda_chain[STAGES-1];
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [(2**AW)-1:0] RO_MASK = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 2**AW;

   logic [DEPTH*DW-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      if (RO_MASK[i]) begin : g_ro
         assign flat[i*DW +: DW] = '0;
      end else begin : g_rw
         logic [DW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && waddr == AW'(i))
               q <= wdata;
         end
         assign flat[i*DW +: DW] = q;
      end
   end

   assign rdata = flat[raddr*DW +: DW];
endmodule

// File: rtl/twi_engine.sv
module twi_engine
   import twi_pkg::*;
#(
   parameter int         AW        = 8,
   parameter int         STRAP_W   = 5,
   parameter logic [6:0] ADDR_BASE = 7'h00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_ev,
   input  logic               stop_ev,
   input  logic [7:0]         rdata,
   output logic               wr_en,
   output logic [AW-1:0]      ptr,
   output logic [7:0]         wr_data,
   output logic               matched,
   output logic               sda_oe
);
   localparam logic [6:0] LO_M = 7'((8'd1 << STRAP_W) - 8'd1);

   twi_state_e         state;
   logic [3:0]         cnt;
   logic [7:0]         sh, txs;
   logic [STRAP_W-1:0] strap_q;
   logic               armed, rw, first, mack;
   logic [6:0]         dev_addr;

   assign dev_addr = (ADDR_BASE & ~LO_M) | 7'(strap_q);
   assign wr_en    = (state == ST_WR) && scl_fall && (cnt == 4'd8) && !first;
   assign wr_data  = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         txs     <= '0;
         strap_q <= '0;
         armed   <= 1'b0;
         rw      <= 1'b0;
         first   <= 1'b0;
         mack    <= 1'b0;
         matched <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
      end else if (!armed) begin
         strap_q <= strap;
         armed   <= 1'b1;
      end else if (start_ev) begin
         state  <= ST_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (stop_ev) begin
         state   <= ST_IDLE;
         sda_oe  <= 1'b0;
         matched <= 1'b0;
         if (matched) ptr <= '0;
      end else begin
         case (state)
            ST_ADDR, ST_WR: begin
               if (scl_rise && cnt != 4'd8) begin
                  sh  <= {sh[6:0], sda_s};
                  cnt <= cnt + 4'd1;
               end else if (scl_fall && cnt == 4'd8) begin
                  if (state == ST_ADDR) begin
                     if (sh[7:1] == dev_addr) begin
                        matched <= 1'b1;
                        rw      <= sh[0];
                        sda_oe  <= 1'b1;
                        state   <= ST_AACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     ptr    <= first ? AW'(sh) : ptr + AW'(1);
                     first  <= 1'b0;
                     sda_oe <= 1'b1;
                     state  <= ST_WACK;
                  end
               end
            end
            ST_AACK, ST_RACK: begin
               if (scl_rise && state == ST_RACK) begin
                  mack <= ~sda_s;
               end else if (scl_fall) begin
                  cnt <= '0;
                  if ((state == ST_AACK && rw) || (state == ST_RACK && mack)) begin
                     txs    <= {rdata[6:0], 1'b0};
                     sda_oe <= ~rdata[7];
                     ptr    <= ptr + AW'(1);
                     state  <= ST_RD;
                  end else if (state == ST_AACK) begin
                     sda_oe <= 1'b0;
                     first  <= 1'b1;
                     state  <= ST_WR;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_IDLE;
                  end
               end
            end
            ST_WACK: begin
               if (scl_fall) begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  state  <= ST_WR;
               end
            end
            ST_RD: begin
               if (scl_rise) begin
                  cnt <= cnt + 4'd1;
               end else if (scl_fall) begin
                  if (cnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else begin
                     sda_oe <= ~txs[7];
                     txs    <= {txs[6:0], 1'b0};
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
   parameter int                 AW        = 8,
   parameter int                 STRAP_W   = 5,
   parameter int                 SYNC_N    = 2,
   parameter logic [6:0]         ADDR_BASE = 7'h00,
   parameter logic [(2**AW)-1:0] RO_MASK   = {{16{1'b1}}, {((2**AW)-16){1'b0}}}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap,
   input  logic               scl_in,
   input  logic               sda_in,
   output logic               sda_oe
);
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
      $error("STRAP_W must lie in 1..6");
   end
   if (AW < 5 || AW > 8) begin : g_bad_aw
      $error("AW must lie in 5..8");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end

   logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic          wr_en, matched;
   logic [AW-1:0] ptr;
   logic [7:0]    wr_data, rdata;

   twi_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   twi_engine #(.AW(AW), .STRAP_W(STRAP_W), .ADDR_BASE(ADDR_BASE)) u_eng (
      .clk(clk), .rst_n(rst_n), .strap(strap), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
      .stop_ev(stop_ev), .rdata(rdata), .wr_en(wr_en), .ptr(ptr),
      .wr_data(wr_data), .matched(matched), .sda_oe(sda_oe)
   );

   twi_regfile #(.AW(AW), .DW(8), .RO_MASK(RO_MASK)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(wr_data),
      .raddr(ptr), .rdata(rdata)
   );
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sda_oe,
   input logic          matched,
   input logic [AW-1:0] ptr,
   input logic          start_ev,
   input logic          stop_ev,
   input logic          scl_fall,
   input logic          wr_en
);
   // R11
   p_oe_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_ev || stop_ev));

   // R7
   p_oe_needs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> matched);

   // R6
   p_stop_clears_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ev && matched) |=> (ptr == '0));

   // R5
   p_start_keeps_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (ptr == $past(ptr)));

   // R4
   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == $past(ptr) + AW'(1)));
endmodule

bind twi_reg_slave twi_reg_slave_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .matched(matched), .ptr(ptr),
   .start_ev(start_ev), .stop_ev(stop_ev), .scl_fall(scl_fall), .wr_en(wr_en)
);

// File: tb/tb_twi_reg_slave.sv
`timescale 1ns/1ps
module tb_twi_reg_slave;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] strap = 5'b01111;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_oe;
   wire        sda_line = ~(m_low | sda_oe);

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] act_q[$];

   always #2.5 clk = ~clk;

   twi_reg_slave dut (
      .clk(clk), .rst_n(rst_n), .strap(strap),
      .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
   );

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items as the design produces read bytes
   initial begin
      forever begin
         wait (act_q.size() > 0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected byte", act_q[0], 8'h00);
            void'(act_q.pop_front());
         end else begin
            logic [7:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(a == e, t, a, e);
         end
      end
   end

   task automatic wq(input int n = 1);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         m_low = ~b[i]; wq(); scl = 1'b1; wq(2); scl = 1'b0;
      end
      m_low = 1'b0; wq(); scl = 1'b1; wq();
      acked = ~sda_line;
      wq(); scl = 1'b0; wq();
   endtask

   task automatic recv_byte(input bit give_ack);
      logic [7:0] b;
      for (int i = 7; i >= 0; i--) begin
         scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq(2);
      end
      m_low = give_ack; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq(); m_low = 1'b0;
      act_q.push_back(b);
   endtask

   task automatic expect_rd(input logic [7:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic addr_phase(input logic [6:0] a, input bit rd, input bit exp_ack, input string tag);
      bit ak;
      send_byte({a, rd}, ak);
      chk(ak == exp_ack, tag, 8'(ak), 8'(exp_ack));
   endtask

   task automatic wr_regs(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d[$], input string tag);
      bit ak;
      bus_start();
      addr_phase(a, 1'b0, 1'b1, {tag, " R3 addr ack"});
      send_byte(p, ak);
      chk(ak, {tag, " R3 ptr ack"}, 8'(ak), 8'h01);
      foreach (d[i]) begin
         send_byte(d[i], ak);
         chk(ak, {tag, " R3 data ack"}, 8'(ak), 8'h01);
      end
      bus_stop();
   endtask

   task automatic rd_regs(input logic [6:0] a, input int n);
      bus_start();
      addr_phase(a, 1'b1, 1'b1, "R2 read addr ack");
      for (int i = 0; i < n; i++) recv_byte(i != n - 1);
      wq();
      chk(sda_oe == 1'b0, "R8 released after NACK", 8'(sda_oe), 8'h00);
      bus_stop();
   endtask

   initial begin
      bit ak;
      repeat (10) @(negedge clk);
      chk(sda_oe == 1'b0, "R10 reset sda released", 8'(sda_oe), 8'h00);
      rst_n = 1'b1;
      wq();
      strap = 5'b00000;   // R1: must not matter after capture

      // R10: registers reset to zero, pointer at zero
      expect_rd(8'h00, "R10 reg00 after reset");
      expect_rd(8'h00, "R10 reg01 after reset");
      rd_regs(7'h0F, 2);

      // R4 burst write, then R5 combined write-pointer / read
      wr_regs(7'h0F, 8'h10, '{8'h11, 8'h22, 8'h3C}, "R4 burst");
      expect_rd(8'h11, "R5 combined rd0");
      expect_rd(8'h22, "R4 combined rd1");
      expect_rd(8'h3C, "R4 combined rd2");
      bus_start();
      addr_phase(7'h0F, 1'b0, 1'b1, "R1 addr after strap change");
      send_byte(8'h10, ak);
      bus_start();
      addr_phase(7'h0F, 1'b1, 1'b1, "R5 read after Sr ack");
      recv_byte(1); recv_byte(1); recv_byte(0);
      bus_stop();

      // R6: read after STOP starts at 0x00
      wr_regs(7'h0F, 8'h00, '{8'h5A, 8'h6B}, "R6 setup");
      expect_rd(8'h5A, "R6 read after stop reg00");
      expect_rd(8'h6B, "R4 read increments reg01");
      rd_regs(7'h0F, 2);

      // R5: pointer advanced by writes persists across Sr
      wr_regs(7'h0F, 8'h20, '{8'h77, 8'h88}, "R5 setup");
      bus_start();
      addr_phase(7'h0F, 1'b0, 1'b1, "R5 addr");
      send_byte(8'h20, ak);
      send_byte(8'h99, ak);
      bus_start();
      addr_phase(7'h0F, 1'b1, 1'b1, "R5 Sr read addr");
      expect_rd(8'h88, "R5 pointer kept after write");
      recv_byte(0);
      bus_stop();

      // R2: MSB-first pattern
      wr_regs(7'h0F, 8'h40, '{8'h81, 8'h01}, "R2 setup");
      bus_start(); addr_phase(7'h0F, 1'b0, 1'b1, "R2 addr"); send_byte(8'h40, ak);
      bus_start(); addr_phase(7'h0F, 1'b1, 1'b1, "R2 rd addr");
      expect_rd(8'h81, "R2 msb first 81");
      expect_rd(8'h01, "R2 msb first 01");
      recv_byte(1); recv_byte(0); bus_stop();

      // R7: non-matching address ignored
      bus_start();
      addr_phase(7'h0E, 1'b0, 1'b0, "R7 no ack wrong addr");
      send_byte(8'h00, ak);
      chk(!ak, "R7 no ack on data", 8'(ak), 8'h00);
      send_byte(8'hEE, ak);
      bus_stop();
      expect_rd(8'h5A, "R7 reg00 unchanged");
      rd_regs(7'h0F, 1);

      // R9: read-only registers and wrap 0xFF -> 0x00
      wr_regs(7'h0F, 8'hEE, '{8'h12, 8'h34, 8'h56}, "R9 setup");
      bus_start(); addr_phase(7'h0F, 1'b0, 1'b1, "R9 addr"); send_byte(8'hEE, ak);
      bus_start(); addr_phase(7'h0F, 1'b1, 1'b1, "R9 rd addr");
      expect_rd(8'h12, "R9 rw EE");
      expect_rd(8'h34, "R9 rw EF");
      expect_rd(8'h00, "R9 ro F0 ignored");
      recv_byte(1); recv_byte(1); recv_byte(0); bus_stop();
      wr_regs(7'h0F, 8'hFF, '{8'hC1, 8'hC2}, "R9 wrap");
      bus_start(); addr_phase(7'h0F, 1'b0, 1'b1, "R9 addr2"); send_byte(8'hFF, ak);
      bus_start(); addr_phase(7'h0F, 1'b1, 1'b1, "R9 rd addr2");
      expect_rd(8'h00, "R9 ro FF ignored");
      expect_rd(8'hC2, "R4 wrap to reg00");
      recv_byte(1); recv_byte(0); bus_stop();

      // R1: new strap value at a later reset
      rst_n = 1'b0; strap = 5'b00011; wq(); rst_n = 1'b1; wq(); strap = 5'b11111;
      bus_start(); addr_phase(7'h0F, 1'b0, 1'b0, "R1 old addr nacked"); bus_stop();
      bus_start(); addr_phase(7'h03, 1'b0, 1'b1, "R1 new addr acked"); bus_stop();

      wq(4);
      wait (act_q.size() == 0);
      chk(exp_q.size() == 0, "R8 all expected bytes seen", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule